// File: doc/BRIEF.md
# Ternary Timed XOR Cell

This block is a two-input logic cell working on signed three-valued signals. Each line carries -1 or +1 as data, or 0 when it is neutral and carries nothing. When both inputs hold data while the cell is idle, the cell captures them and works out an exclusive-or style result: -1 when the two values agree, +1 when they differ.

The result is not driven straight away. It appears on the output after a set processing delay, counted in clock edges. It then stays on the output for a set clearing delay, and after that the output falls back to neutral by itself. While a computation is running, the inputs are not looked at. Both delays are parameters. The cell is meant to be chained, with its output pulse acting as a data event for the next cell.

Top module: `tern_xor_cell`

## Requirements
- R1: Each ternary signal is 2 bits wide, coded 2'b00 = neutral (0), 2'b01 = +1 and 2'b11 = -1. The code 2'b10 is illegal and is treated as neutral on an input.
- R2: When both captured operands are equal (both +1 or both -1), the result driven is -1 (2'b11).
- R3: When the captured operands differ, the result driven is +1 (2'b01).
- R4: The cell captures the inputs on the first rising edge at which it is idle and both inputs hold data. The result appears on `tx_out` exactly `PROC_DLY` edges after that capture edge, and `tx_out` stays neutral until then.
- R5: The result stays on `tx_out` for exactly `CLR_DLY` edges and then returns to 2'b00.
- R6: Input changes after the capture edge, up to and including the edge on which the output clears, have no effect on the result.
- R7: While either input is neutral or illegal, no capture takes place and `tx_out` stays 2'b00.
- R8: A synchronous active-high `rst` forces `tx_out` to 2'b00 and clears the delay counter. A computation in progress is abandoned and produces no result.
- R9: `PROC_DLY` and `CLR_DLY` both default to 100 clock edges.
- R10: `tx_out` never carries the illegal code 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_a | input | 2 | First ternary operand |
| tx_b | input | 2 | Second ternary operand |
| tx_out | output | 2 | Registered ternary result pulse |

## Verification
On every cycle the bound checker enforces the following:
- the output code is always legal;
- the output is neutral outside the display phase and after reset;
- a displayed value holds until it drops to neutral;
- the first non-neutral value matches the agree/differ rule for the captured operands;
- that first value appears exactly the processing delay after capture, measured with a counter kept in the checker.

Some behaviour can only be shown by the bench's scenarios, which run at the default delays. The bench shows that inputs changed mid-computation leave the result unchanged, and that an illegal code on one input blocks a capture. It also shows that a reset in mid-flight suppresses the pending pulse, and that the output clears after exactly the clearing delay.

// File: rtl/tern_xor_pkg.sv
package tern_xor_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_POS  = 2'b01;
  localparam trit_t TRIT_NEG  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROC = 2'd1,
    PH_SHOW = 2'd2
  } phase_t;

  // Only the two data codes count; 2'b10 behaves like neutral.
  function automatic logic trit_is_data(input trit_t t);
    return (t == TRIT_POS) || (t == TRIT_NEG);
  endfunction

endpackage

// File: rtl/tern_qualify.sv
// Reports whether every lane of a packed ternary bus carries a data value.
module tern_qualify
  import tern_xor_pkg::*;
#(
  parameter int NUM_LANES = 2,
  localparam int BUS_W = 2 * NUM_LANES
) (
  input  logic [BUS_W-1:0] lanes,
  output logic             all_data
);

  logic [NUM_LANES-1:0] lane_ok;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_ok[g] = trit_is_data(trit_t'(lanes[2*g +: 2]));
  end

  assign all_data = &lane_ok;

endmodule

// File: rtl/tern_xor_core.sv
// Agree -> -1, differ -> +1, on two already-qualified operands.
module tern_xor_core
  import tern_xor_pkg::*;
(
  input  trit_t op_a,
  input  trit_t op_b,
  output trit_t result
);

  always_comb begin
    if (op_a == op_b) result = TRIT_NEG;
    else              result = TRIT_POS;
  end

endmodule

// File: rtl/tern_phase_ctrl.sv
// Idle -> processing -> showing -> idle; one shared counter times both waits.
module tern_phase_ctrl
  import tern_xor_pkg::*;
#(
  parameter int PROC_DLY = 100,
  parameter int CLR_DLY  = 100,
  localparam int MAX_DLY = (PROC_DLY > CLR_DLY) ? PROC_DLY : CLR_DLY,
  localparam int CNT_W   = $clog2(MAX_DLY + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   done
);

  localparam logic [CNT_W-1:0] PROC_LIM = CNT_W'(PROC_DLY);
  localparam logic [CNT_W-1:0] CLR_LIM  = CNT_W'(CLR_DLY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // done marks the edge that ends the current wait
  always_comb begin
    case (phase)
      PH_PROC: done = (cnt_q == PROC_LIM);
      PH_SHOW: done = (cnt_q == CLR_LIM);
      default: done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_PROC;
            cnt_q <= CNT_ONE;
          end
        end
        PH_PROC: begin
          if (done) begin
            phase <= PH_SHOW;
            cnt_q <= CNT_ONE;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        PH_SHOW: begin
          if (done) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/tern_xor_cell.sv
module tern_xor_cell
  import tern_xor_pkg::*;
#(
  parameter int PROC_DLY = 100,
  parameter int CLR_DLY  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tx_a,
  input  logic [1:0] tx_b,
  output logic [1:0] tx_out
);

  logic   inputs_ready;
  logic   load;
  logic   done;
  phase_t phase;
  trit_t  cap_a;
  trit_t  cap_b;
  trit_t  result;
  trit_t  out_q;

  tern_qualify #(.NUM_LANES(2)) u_qualify (
    .lanes    ({tx_b, tx_a}),
    .all_data (inputs_ready)
  );

  assign load = (phase == PH_IDLE) && inputs_ready;

  tern_phase_ctrl #(.PROC_DLY(PROC_DLY), .CLR_DLY(CLR_DLY)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (load),
    .phase (phase),
    .done  (done)
  );

  // Operands are frozen at capture; inputs are ignored until the next idle phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a <= TRIT_ZERO;
      cap_b <= TRIT_ZERO;
    end else if (load) begin
      cap_a <= trit_t'(tx_a);
      cap_b <= trit_t'(tx_b);
    end
  end

  tern_xor_core u_core (
    .op_a   (cap_a),
    .op_b   (cap_b),
    .result (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= TRIT_ZERO;
    end else if (done && (phase == PH_PROC)) begin
      out_q <= result;
    end else if (done && (phase == PH_SHOW)) begin
      out_q <= TRIT_ZERO;
    end
  end

  assign tx_out = out_q;

endmodule

// File: rtl/tern_xor_cell_chk.sv
module tern_xor_cell_chk
  import tern_xor_pkg::*;
#(
  parameter int PROC_DLY = 100,
  parameter int CLR_DLY  = 100
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] tx_a,
  input logic [1:0] tx_b,
  input logic [1:0] tx_out,
  input phase_t     phase,
  input trit_t      cap_a,
  input trit_t      cap_b
);

  // Edges since capture, saturating; measures the long processing window.
  logic [31:0] since_cap;

  always_ff @(posedge clk) begin
    if (rst) since_cap <= '0;
    else if ((phase == PH_IDLE) && trit_is_data(tx_a) && trit_is_data(tx_b)) since_cap <= 32'd1;
    else if ((since_cap != 32'd0) && (since_cap < 32'hFFFF_FFF0)) since_cap <= since_cap + 32'd1;
  end

  // R10
  out_legal_chk: assert property (@(posedge clk) disable iff (rst)
    tx_out != 2'b10);

  // R7
  out_neutral_off_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_SHOW) |-> (tx_out == TRIT_ZERO));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (tx_out == TRIT_ZERO));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_out != TRIT_ZERO) |=> ((tx_out == $past(tx_out)) || (tx_out == TRIT_ZERO)));

  // R2 R3
  result_rule_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_out != TRIT_ZERO) && ($past(tx_out) == TRIT_ZERO))
      |-> ((tx_out == TRIT_NEG) == (cap_a == cap_b)));

  // R4 (counter is already one past the firing edge when sampled)
  proc_delay_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_out != TRIT_ZERO) && ($past(tx_out) == TRIT_ZERO))
      |-> (since_cap == 32'(PROC_DLY + 1)));

endmodule

bind tern_xor_cell tern_xor_cell_chk #(.PROC_DLY(PROC_DLY), .CLR_DLY(CLR_DLY)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .tx_a   (tx_a),
  .tx_b   (tx_b),
  .tx_out (tx_out),
  .phase  (phase),
  .cap_a  (cap_a),
  .cap_b  (cap_b)
);

// File: tb/test_tern_xor_cell.sv
module test_tern_xor_cell;

  localparam int CLK_PERIOD = 10;
  localparam int P = 100;  // R9 default processing delay
  localparam int C = 100;  // R9 default clearing delay
  localparam logic [1:0] ZR = 2'b00, PO = 2'b01, NE = 2'b11, IL = 2'b10;

  // {a, b, expected}
  localparam logic [5:0] VEC [4] = '{
    {NE, NE, NE},
    {PO, NE, PO},
    {NE, PO, PO},
    {PO, PO, NE}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tx_a = ZR;
  logic [1:0] tx_b = ZR;
  logic [1:0] tx_out;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tern_xor_cell i_tern_xor_cell (
    .clk    (clk),
    .rst    (rst),
    .tx_a   (tx_a),
    .tx_b   (tx_b),
    .tx_out (tx_out)
  );

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (tx_out !== exp) begin
      errors++;
      $display("FAIL %s: tx_out=%b expected=%b at %0t", req, tx_out, exp, $time);
    end
  endtask

  task automatic run_case(input logic [1:0] a, input logic [1:0] b, input logic [1:0] exp);
    @(negedge clk); tx_a = a; tx_b = b;
    @(posedge clk);                        // capture edge
    @(negedge clk); tx_a = (a == PO) ? NE : PO; tx_b = b;  // R6 disturb
    repeat (P - 1) @(posedge clk);
    @(negedge clk); check("R4 (R9 timing) still neutral", ZR);
    @(posedge clk);
    @(negedge clk); check("R2/R3 result at processing delay", exp);
    repeat (C - 1) @(posedge clk);
    @(negedge clk); check("R6 result unaffected, R5 still held", exp);
    @(posedge clk);
    @(negedge clk); check("R5 cleared after clearing delay", ZR);
    tx_a = ZR; tx_b = ZR;
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); check("R8 reset state", ZR);
    rst = 1'b0;

    for (int i = 0; i < 4; i++) begin
      run_case(VEC[i][5:4], VEC[i][3:2], VEC[i][1:0]);
    end

    // R7: one neutral input, hold well past a full pulse time
    @(negedge clk); tx_a = PO; tx_b = ZR;
    repeat (P + 5) @(posedge clk);
    @(negedge clk); check("R7 neutral input gives no result", ZR);
    repeat (C) @(posedge clk);
    @(negedge clk); check("R7 output stays neutral", ZR);

    // R1: illegal code acts as neutral
    tx_a = IL; tx_b = NE;
    repeat (P + 5) @(posedge clk);
    @(negedge clk); check("R1 illegal code treated as neutral", ZR);
    tx_a = ZR; tx_b = ZR;
    @(posedge clk);

    // R8: reset in the middle of processing aborts the pulse
    @(negedge clk); tx_a = PO; tx_b = NE;
    @(posedge clk);
    @(negedge clk); tx_a = ZR; tx_b = ZR;
    repeat (10) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); check("R8 output neutral under reset", ZR); rst = 1'b0;
    repeat (P + 5) @(posedge clk);
    @(negedge clk); check("R8 aborted computation yields nothing", ZR);

    // after the abort a fresh computation works normally
    run_case(NE, PO, PO);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // R10: legality of the output code on every sampled cycle
  always @(negedge clk) begin
    if (!rst && tx_out == IL) begin
      errors++;
      $display("FAIL R10: tx_out=%b expected legal code", tx_out);
    end
  end

endmodule